// File: doc/BRIEF.md
# System Control Register File

This block is a small bank of chip-level control registers on a simple memory-mapped bus. The bus has a byte address, a write strobe, 32-bit write data and 32-bit read data. Every access is a whole 32-bit word. There are no byte enables and no handshake. Read data follows the address combinationally, and a write takes effect on the clock edge where the strobe is sampled.

The bank holds the following registers:

- a protection lock;
- a board strapping register, which loads from the strap pins during reset;
- a silicon revision register, which reads back the revision input;
- a scratch word, which resets with a memory-initialisation-done flag;
- a parameterised set of generic control words, whose reset values depend on the revision input.

While the lock is engaged, writes to every register except the lock are discarded.

The build parameter `SET_CLEAR` selects how firmware changes the strapping register:

- With `SET_CLEAR=0` (older style), a write simply replaces the strap value.
- With `SET_CLEAR=1` (newer style), a write to the strap offset only sets bits, and a write to the revision offset clears strap bits. The revision value itself never changes.

Top module: `sysctl_regs`

## Requirements
- R1: While the lock is engaged, a write to any offset other than 0x00 leaves every register unchanged.
- R2: Writing 0x5CA1AB1E to offset 0x00 releases the lock, and writing any other value there engages it. A read of 0x00 returns 1 when the lock is released and 0 when it is engaged.
- R3: After reset the lock is engaged, unless `boot_unlocked` is high during reset, in which case it is released.
- R4: With `SET_CLEAR=0`, an unlocked write to offset 0x04 replaces the strap value, and a write to offset 0x08 has no effect on it.
- R5: With `SET_CLEAR=1`, an unlocked write to offset 0x04 sets each strap bit that is 1 in the write data and keeps all other strap bits.
- R6: With `SET_CLEAR=1`, an unlocked write to offset 0x08 clears each strap bit that is 1 in the write data, and the revision read is unchanged.
- R7: A read of offset 0x08 always returns `rev_id`. No write alters it.
- R8: The strap register (offset 0x04) takes the value of `strap_pins` during reset.
- R9: The scratch register at 0x0C resets to 0x00000040 (bit 6 is the memory-init-done flag) and holds any value written while unlocked.
- R10: Control word n sits at offset 0x10+4n. Its reset value depends on `rev_id`:
  - 0x02000303 gives 0xF0000000+n;
  - 0x04000303 gives 0xA5000000+16n;
  - any other revision gives 0.

  Each control word holds the value written to it while unlocked.
- R11: Unmapped offsets read as zero and ignore writes. This includes offsets that are not word aligned and offsets past the last control word.
- R12: A write becomes visible on the read port in the cycle that follows the clock edge on which the strobe was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boot_unlocked | input | 1 | During reset, selects a released lock |
| rev_id | input | 32 | Silicon revision; also selects the reset value set |
| strap_pins | input | 32 | Board strap levels loaded into the strap register during reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
The hardest state to reach is a strap register that has been changed in both directions in the set/clear variant. Reaching it takes three steps in order: the correct key, a set through the strap offset, and a clear through the revision offset. The revision read must stay the same throughout. The bench drives this sequence on two instances at once, one built for each variant, so that a single stream of writes shows the OR, the AND-NOT, and the replace-and-ignore behaviour against one reference model. It then repeats resets with different revision and strap inputs, so that each set of reset values and the unlocked-boot option are all observed.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int          DATA_W        = 32;
  localparam logic [7:0]  OFS_LOCK      = 8'h00;
  localparam logic [7:0]  OFS_STRAP     = 8'h04;
  localparam logic [7:0]  OFS_REV       = 8'h08;
  localparam logic [7:0]  OFS_SCRATCH   = 8'h0C;
  localparam logic [7:0]  OFS_CTRL_BASE = 8'h10;

  localparam logic [31:0] UNLOCK_KEY    = 32'h5CA1_AB1E;
  localparam logic [31:0] REV_GEN_A     = 32'h0200_0303;
  localparam logic [31:0] REV_GEN_B     = 32'h0400_0303;
  localparam int          MEMINIT_BIT   = 6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOCK,
    SEL_STRAP,
    SEL_REV,
    SEL_SCRATCH,
    SEL_CTRL
  } reg_sel_e;

  // Reset value of a generic control word for a given revision.
  function automatic logic [31:0] ctrl_reset_value(input logic [31:0] rev, input int idx);
    logic [31:0] v;
    if (rev == REV_GEN_A)      v = 32'hF000_0000 + 32'(idx);
    else if (rev == REV_GEN_B) v = 32'hA500_0000 + (32'(idx) << 4);
    else                       v = '0;
    return v;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_CTRL = 4,
  localparam int CIDX_W  = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic [CIDX_W-1:0] ctrl_idx
);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    sel      = SEL_NONE;
    ctrl_idx = '0;
    rel      = bus_addr - ADDR_W'(OFS_CTRL_BASE);
    if (bus_addr == ADDR_W'(OFS_LOCK))         sel = SEL_LOCK;
    else if (bus_addr == ADDR_W'(OFS_STRAP))   sel = SEL_STRAP;
    else if (bus_addr == ADDR_W'(OFS_REV))     sel = SEL_REV;
    else if (bus_addr == ADDR_W'(OFS_SCRATCH)) sel = SEL_SCRATCH;
    else if ((bus_addr >= ADDR_W'(OFS_CTRL_BASE)) && (rel[1:0] == 2'b00) &&
             ((rel >> 2) < ADDR_W'(NUM_CTRL))) begin
      sel      = SEL_CTRL;
      ctrl_idx = CIDX_W'(rel >> 2);
    end
  end

endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_unlocked,
  input  logic        lock_wr,
  input  logic [31:0] wdata,
  output logic        unlocked
);

  logic unlocked_d;
  logic unlocked_en;

  always_comb begin
    unlocked_en = lock_wr;
    unlocked_d  = (wdata == UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           unlocked <= boot_unlocked;
    else if (unlocked_en) unlocked <= unlocked_d;
  end

endmodule

// File: rtl/sysctl_strap.sv
module sysctl_strap #(
  parameter bit SET_CLEAR = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] strap_pins,
  input  logic        set_wr,
  input  logic        clr_wr,
  input  logic [31:0] wdata,
  output logic [31:0] strap_q
);

  logic [31:0] strap_d;
  logic        strap_en;

  generate
    if (SET_CLEAR) begin : g_set_clear
      always_comb begin
        strap_en = set_wr | clr_wr;
        if (set_wr) strap_d = strap_q | wdata;
        else        strap_d = strap_q & ~wdata;
      end
    end else begin : g_replace
      // A clear strobe carries no meaning here and keeps the value.
      always_comb begin
        strap_en = set_wr | clr_wr;
        strap_d  = clr_wr ? strap_q : wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        strap_q <= strap_pins;
    else if (strap_en) strap_q <= strap_d;
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CTRL  = 4,
  parameter bit SET_CLEAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_unlocked,
  input  logic [31:0]       rev_id,
  input  logic [31:0]       strap_pins,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int CIDX_W = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1;

  reg_sel_e                       sel;
  logic [CIDX_W-1:0]              ctrl_idx;
  logic                           unlocked;
  logic                           wr_open;
  logic [31:0]                    strap_q;
  logic [31:0]                    scratch_q;
  logic [31:0]                    scratch_d;
  logic                           scratch_en;
  logic [NUM_CTRL-1:0][31:0]      ctrl_q;

  sysctl_decode #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL)) u_decode (
    .bus_addr (bus_addr),
    .sel      (sel),
    .ctrl_idx (ctrl_idx)
  );

  sysctl_lock u_lock (
    .clk           (clk),
    .rst_n         (rst_n),
    .boot_unlocked (boot_unlocked),
    .lock_wr       (bus_wr && (sel == SEL_LOCK)),
    .wdata         (bus_wdata),
    .unlocked      (unlocked)
  );

  assign wr_open = bus_wr & unlocked;

  sysctl_strap #(.SET_CLEAR(SET_CLEAR)) u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_pins (strap_pins),
    .set_wr     (wr_open && (sel == SEL_STRAP)),
    .clr_wr     (SET_CLEAR && wr_open && (sel == SEL_REV)),
    .wdata      (bus_wdata),
    .strap_q    (strap_q)
  );

  // Scratch word
  always_comb begin
    scratch_en = wr_open && (sel == SEL_SCRATCH);
    scratch_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          scratch_q <= 32'(1) << MEMINIT_BIT;
    else if (scratch_en) scratch_q <= scratch_d;
  end

  // Generic control words
  generate
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
      logic ctrl_en;
      always_comb ctrl_en = wr_open && (sel == SEL_CTRL) && (ctrl_idx == CIDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q[g] <= ctrl_reset_value(rev_id, g);
        else if (ctrl_en) ctrl_q[g] <= bus_wdata;
      end
    end
  endgenerate

  // Read path
  always_comb begin
    case (sel)
      SEL_LOCK:    bus_rdata = {31'b0, unlocked};
      SEL_STRAP:   bus_rdata = strap_q;
      SEL_REV:     bus_rdata = rev_id;
      SEL_SCRATCH: bus_rdata = scratch_q;
      SEL_CTRL:    bus_rdata = ctrl_q[ctrl_idx];
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CTRL  = 4,
  parameter bit SET_CLEAR = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       rev_id,
  input logic              unlocked,
  input logic [31:0]       strap_q,
  input logic [31:0]       scratch_q
);

  localparam logic [ADDR_W-1:0] FREE_OFS = ADDR_W'(int'(OFS_CTRL_BASE) + 4 * NUM_CTRL);

  assert_lock_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_wr && bus_addr == ADDR_W'(OFS_SCRATCH)) |=> $stable(scratch_q));

  assert_bad_key_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_LOCK) && bus_wdata != UNLOCK_KEY) |=> !unlocked);

  assert_replace_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!SET_CLEAR && unlocked && bus_wr && bus_addr == ADDR_W'(OFS_STRAP))
      |=> (strap_q == $past(bus_wdata)));

  assert_set_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_CLEAR && unlocked && bus_wr && bus_addr == ADDR_W'(OFS_STRAP))
      |=> ((strap_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clear_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_CLEAR && unlocked && bus_wr && bus_addr == ADDR_W'(OFS_REV))
      |=> ((strap_q & $past(bus_wdata)) == 32'h0));

  assert_rev_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_REV)) |-> (bus_rdata == rev_id));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == FREE_OFS) |-> (bus_rdata == 32'h0));

endmodule

bind sysctl_regs sysctl_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .SET_CLEAR(SET_CLEAR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rev_id    (rev_id),
  .unlocked  (unlocked),
  .strap_q   (strap_q),
  .scratch_q (scratch_q)
);

// File: tb/test_sysctl_regs.sv
`timescale 1ns/1ps
module test_sysctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        boot_unlocked = 1'b0;
  logic [31:0] rev_id = 32'h0;
  logic [31:0] strap_pins = 32'h0;
  logic [7:0]  bus_addr = 8'h0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] rdata_sc;
  logic [31:0] rdata_rmw;

  int checks = 0;
  int failures = 0;
  bit model_ready = 1'b0;

  always #10 clk = ~clk;

  sysctl_regs #(.SET_CLEAR(1'b1)) i_sysctl_regs (
    .clk(clk), .rst_n(rst_n), .boot_unlocked(boot_unlocked), .rev_id(rev_id),
    .strap_pins(strap_pins), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_sc)
  );

  sysctl_regs #(.SET_CLEAR(1'b0)) i_sysctl_regs_rmw (
    .clk(clk), .rst_n(rst_n), .boot_unlocked(boot_unlocked), .rev_id(rev_id),
    .strap_pins(strap_pins), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_rmw)
  );

  // Behavioural reference model
  bit          m_unlocked;
  logic [31:0] m_strap_sc, m_strap_rmw, m_scratch;
  logic [31:0] m_ctrl [4];

  function automatic logic [31:0] ctrl_rst(input logic [31:0] rev, input int n);
    if (rev == 32'h0200_0303) return 32'hF000_0000 + 32'(n);
    if (rev == 32'h0400_0303) return 32'hA500_0000 + 32'(16 * n);
    return 32'h0;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a, input bit rmw);
    if (a == 8'h00) return {31'b0, m_unlocked};
    if (a == 8'h04) return rmw ? m_strap_rmw : m_strap_sc;
    if (a == 8'h08) return rev_id;
    if (a == 8'h0C) return m_scratch;
    if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00) return m_ctrl[(a - 8'h10) >> 2];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_unlocked  = boot_unlocked;
      m_strap_sc  = strap_pins;
      m_strap_rmw = strap_pins;
      m_scratch   = 32'h0000_0040;
      for (int n = 0; n < 4; n++) m_ctrl[n] = ctrl_rst(rev_id, n);
      model_ready = 1'b1;
    end else if (bus_wr) begin
      if (bus_addr == 8'h00) m_unlocked = (bus_wdata == 32'h5CA1_AB1E);
      else if (m_unlocked) begin
        if (bus_addr == 8'h04) begin
          m_strap_sc  = m_strap_sc | bus_wdata;
          m_strap_rmw = bus_wdata;
        end else if (bus_addr == 8'h08) m_strap_sc = m_strap_sc & ~bus_wdata;
        else if (bus_addr == 8'h0C) m_scratch = bus_wdata;
        else if (bus_addr >= 8'h10 && bus_addr <= 8'h1C && bus_addr[1:0] == 2'b00)
          m_ctrl[(bus_addr - 8'h10) >> 2] = bus_wdata;
      end
    end
  end

  // Cycle-by-cycle comparison of both instances against the model (R12)
  always @(negedge clk) begin
    if (rst_n && model_ready) begin
      checks++;
      if (rdata_sc !== model_read(bus_addr, 1'b0)) begin
        failures++;
        $display("FAIL R12 set/clear addr=%h actual=%h expected=%h", bus_addr, rdata_sc,
                 model_read(bus_addr, 1'b0));
      end
      checks++;
      if (rdata_rmw !== model_read(bus_addr, 1'b1)) begin
        failures++;
        $display("FAIL R12 replace addr=%h actual=%h expected=%h", bus_addr, rdata_rmw,
                 model_read(bus_addr, 1'b1));
      end
    end
  end

  task automatic do_reset(input logic [31:0] rev, input logic [31:0] pins, input bit bu);
    @(negedge clk); #1;
    rst_n = 1'b0; rev_id = rev; strap_pins = pins; boot_unlocked = bu; bus_wr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp_sc,
                           input logic [31:0] exp_rmw, input string tag);
    @(negedge clk); #1;
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    checks++;
    if (rdata_sc !== exp_sc) begin
      failures++;
      $display("FAIL %s set/clear addr=%h actual=%h expected=%h", tag, a, rdata_sc, exp_sc);
    end
    checks++;
    if (rdata_rmw !== exp_rmw) begin
      failures++;
      $display("FAIL %s replace addr=%h actual=%h expected=%h", tag, a, rdata_rmw, exp_rmw);
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Reset with revision A, lock engaged
    do_reset(32'h0200_0303, 32'h1234_5678, 1'b0);
    expect_rd(8'h00, 32'h0, 32'h0, "R3");
    expect_rd(8'h04, 32'h1234_5678, 32'h1234_5678, "R8");
    expect_rd(8'h08, 32'h0200_0303, 32'h0200_0303, "R7");
    expect_rd(8'h0C, 32'h0000_0040, 32'h0000_0040, "R9");
    expect_rd(8'h10, 32'hF000_0000, 32'hF000_0000, "R10");
    expect_rd(8'h1C, 32'hF000_0003, 32'hF000_0003, "R10");
    expect_rd(8'h20, 32'h0, 32'h0, "R11");

    // Writes while locked are dropped
    do_write(8'h0C, 32'hDEAD_BEEF);
    do_write(8'h04, 32'hFFFF_FFFF);
    do_write(8'h08, 32'hFFFF_FFFF);
    do_write(8'h14, 32'h1111_1111);
    expect_rd(8'h0C, 32'h0000_0040, 32'h0000_0040, "R1");
    expect_rd(8'h04, 32'h1234_5678, 32'h1234_5678, "R1");
    expect_rd(8'h14, 32'hF000_0001, 32'hF000_0001, "R1");

    // Key handling
    do_write(8'h00, 32'h5CA1_AB1F);
    expect_rd(8'h00, 32'h0, 32'h0, "R2");
    do_write(8'h00, 32'h5CA1_AB1E);
    expect_rd(8'h00, 32'h1, 32'h1, "R2");

    // Strap set versus replace
    do_write(8'h04, 32'h0000_00F0);
    expect_rd(8'h04, 32'h1234_56F8, 32'h0000_00F0, "R5_R4");
    // Strap clear through the revision offset
    do_write(8'h08, 32'h1200_0008);
    expect_rd(8'h04, 32'h0034_56F0, 32'h0000_00F0, "R6_R4");
    expect_rd(8'h08, 32'h0200_0303, 32'h0200_0303, "R6");

    // Scratch and control words when unlocked
    do_write(8'h0C, 32'hCAFE_0001);
    expect_rd(8'h0C, 32'hCAFE_0001, 32'hCAFE_0001, "R9");
    do_write(8'h18, 32'h7777_0002);
    expect_rd(8'h18, 32'h7777_0002, 32'h7777_0002, "R10");

    // Unmapped and unaligned writes
    do_write(8'h20, 32'h5555_5555);
    do_write(8'h11, 32'h6666_6666);
    expect_rd(8'h20, 32'h0, 32'h0, "R11");
    expect_rd(8'h11, 32'h0, 32'h0, "R11");
    expect_rd(8'h10, 32'hF000_0000, 32'hF000_0000, "R11");
    expect_rd(8'h14, 32'hF000_0001, 32'hF000_0001, "R11");

    // Re-lock and confirm writes drop again
    do_write(8'h00, 32'h0);
    expect_rd(8'h00, 32'h0, 32'h0, "R2");
    do_write(8'h0C, 32'h0BAD_0BAD);
    expect_rd(8'h0C, 32'hCAFE_0001, 32'hCAFE_0001, "R1");

    // Revision B, boot with the lock released
    do_reset(32'h0400_0303, 32'hA5A5_0F0F, 1'b1);
    expect_rd(8'h00, 32'h1, 32'h1, "R3");
    expect_rd(8'h04, 32'hA5A5_0F0F, 32'hA5A5_0F0F, "R8");
    expect_rd(8'h14, 32'hA500_0010, 32'hA500_0010, "R10");
    expect_rd(8'h1C, 32'hA500_0030, 32'hA500_0030, "R10");
    do_write(8'h08, 32'hFFFF_0000);
    expect_rd(8'h04, 32'h0000_0F0F, 32'hA5A5_0F0F, "R6_R4");

    // Unknown revision gives zero control words
    do_reset(32'h0000_0000, 32'h0, 1'b0);
    expect_rd(8'h10, 32'h0, 32'h0, "R10");
    expect_rd(8'h0C, 32'h0000_0040, 32'h0000_0040, "R9");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule